// File: doc/BRIEF.md
# Peripheral Clock Mask Controller

This block holds one enable bit for every peripheral clock in two bus domains: a system-bus (AHB) domain and a peripheral-bus (APB) domain. Each bit drives a latch-and-AND gate, so the gated clocks start and stop without glitches. The registers sit behind an APB slave port. The same port also forwards accesses to the peripherals behind it. An access to a peripheral whose APB clock is masked never reaches that peripheral. It completes at once with an error response and zero read data.

Every bit comes out of reset at its own default value, which a parameter sets. In a typical setup the bridge, DMA, debug, flash-controller, clock-controller and watchdog clocks start enabled, and the timer, serial, analog and event clocks start disabled. Some bits serve the controller itself: its own APB clock bit and the AHB bit of the bridge that carries its traffic. Clearing either of these locks the controller out. From then on every write is ignored and every access returns an error. Only the asynchronous system reset clears the lockout, and it also returns all bits to their defaults.

The bus state machine has two named states. In `S_IDLE` no transfer is in its access phase. The transition `IDLE->ACCESS` fires on a setup phase (select high, enable low). In `S_ACCESS` ready is high and the transfer completes. The transition `ACCESS->IDLE` is unconditional.

Top module: `periph_clk_mask`

## Requirements
- R1: After reset, the AHB mask register reads DEF_AHB and the APB mask register reads DEF_APB. Each gated clock runs exactly when its default bit is 1.
- R2: Writing 1 to a mask bit starts the matching gated clock, and writing 0 stops it. The change is seen from the first rising edge after the write edge.
- R3: A mask change never alters a gated clock during the high phase of the edge that wrote it. Every gated clock is low while its source clock is low.
- R4: In the controller slot, offset 0x00 holds the AHB mask and offset 0x04 holds the APB mask, with bit i gating clock i. Bits above the domain width read 0 and ignore writes. A write to one register leaves the other unchanged.
- R5: The address splits into a slot index (paddr above bit SLOT_BITS) and an offset (the lower SLOT_BITS bits). Slot k is the peripheral gated by APB bit k, and slot SELF_IDX is the controller. Other offsets in the controller slot read 0 without error.
- R6: An access to an enabled slot is forwarded: exactly that per_psel bit goes high, the offset and write data pass through, the peripheral's read data is returned, and pslverr stays 0.
- R7: An access to a slot whose APB bit is 0, or to a slot at or beyond N_APB, is not forwarded. It returns pslverr=1 and prdata=0.
- R8: Writing a cleared APB bit back to 1 restores forwarding for that slot.
- R9: Every transfer completes without wait states. pready is 0 in the setup cycle and 1 in the following cycle.
- R10: Once APB bit SELF_IDX or AHB bit BRG_IDX is 0, the controller is locked out. Writes change no mask bit, and every access returns pslverr=1 with prdata=0 and is not forwarded.
- R11: Asserting rst_ni at any time, including during lockout, returns every mask bit to its default and ends the lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Free-running peripheral-bus clock; also clocks the registers |
| hclk_i | input | 1 | Free-running system-bus clock source for the AHB gates |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access-phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address (slot index and offset) |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, zero on error |
| pready_o | output | 1 | Transfer complete |
| pslverr_o | output | 1 | Error response |
| per_psel_o | output | N_APB | One-hot select toward the peripherals |
| per_penable_o | output | 1 | Access strobe toward the peripherals |
| per_pwrite_o | output | 1 | Direction toward the peripherals |
| per_paddr_o | output | SLOT_BITS | Offset inside the selected slot |
| per_pwdata_o | output | 32 | Write data toward the peripherals |
| per_prdata_i | input | 32*N_APB | Read data from each peripheral, slot k at bits 32k+31:32k |
| ahb_gclk_o | output | N_AHB | Gated AHB-domain clocks |
| apb_gclk_o | output | N_APB | Gated APB-domain clocks |

## Verification
The bench builds the block with N_AHB=4, DEF_AHB=4'b1011, N_APB=6 and DEF_APB=6'b100101, which gives a mix of enabled and disabled defaults in both domains. With ADDR_W=11 and SLOT_BITS=8 the slot field has three bits, so slots 6 and 7 decode to no peripheral and the unpopulated-slot error path can be reached. SELF_IDX=0 and BRG_IDX=0 let one write to either register trigger the lockout, which is then cleared with a reset applied in the middle of a cycle. Gated clocks are sampled in the high phase right after the write edge and one cycle later, to show when a mask change takes effect.

// File: rtl/pcm_pkg.sv
`timescale 1ns/1ps
package pcm_pkg;
    localparam int unsigned DATA_W = 32;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_ACCESS = 1'b1
    } bus_state_e;
endpackage

// File: rtl/pcm_clk_gate.sv
`timescale 1ns/1ps
module pcm_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_lat;

    // transparent only while the source clock is low
    always_latch begin
        if (!clk_i) en_lat <= en_i;
    end

    assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/pcm_mask_regs.sv
`timescale 1ns/1ps
module pcm_mask_regs #(
    parameter int unsigned          N_AHB   = 8,
    parameter int unsigned          N_APB   = 8,
    parameter logic [N_AHB-1:0]     DEF_AHB = '1,
    parameter logic [N_APB-1:0]     DEF_APB = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_ahb_i,
    input  logic             wr_apb_i,
    input  logic [N_AHB-1:0] ahb_wd_i,
    input  logic [N_APB-1:0] apb_wd_i,
    output logic [N_AHB-1:0] ahb_q_o,
    output logic [N_APB-1:0] apb_q_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ahb_q_o <= DEF_AHB;
            apb_q_o <= DEF_APB;
        end else begin
            if (wr_ahb_i) ahb_q_o <= ahb_wd_i;
            if (wr_apb_i) apb_q_o <= apb_wd_i;
        end
    end
endmodule

// File: rtl/pcm_bus_fsm.sv
`timescale 1ns/1ps
module pcm_bus_fsm
    import pcm_pkg::*;
#(
    parameter int unsigned N_AHB     = 8,
    parameter int unsigned N_APB     = 8,
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned SELF_IDX  = 0,
    parameter int unsigned BRG_IDX   = 0
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      psel_i,
    input  logic                      penable_i,
    input  logic                      pwrite_i,
    input  logic [ADDR_W-1:0]         paddr_i,
    input  logic [N_AHB-1:0]          ahb_q_i,
    input  logic [N_APB-1:0]          apb_q_i,
    input  logic [N_APB*DATA_W-1:0]   per_prdata_i,
    output logic [DATA_W-1:0]         prdata_o,
    output logic                      pready_o,
    output logic                      pslverr_o,
    output logic                      wr_ahb_o,
    output logic                      wr_apb_o,
    output logic [N_APB-1:0]          per_psel_o,
    output logic                      locked_o
);
    localparam int unsigned SLOT_W = ADDR_W - SLOT_BITS;
    localparam logic [SLOT_W-1:0]    SELF_SLOT = SELF_IDX[SLOT_W-1:0];
    localparam logic [SLOT_BITS-1:0] OFS_AHB   = SLOT_BITS'(0);
    localparam logic [SLOT_BITS-1:0] OFS_APB   = SLOT_BITS'(4);

    bus_state_e state_q, state_d;

    logic [SLOT_W-1:0]    slot;
    logic [SLOT_BITS-1:0] ofs;
    logic                 is_self, in_range, slot_on, fwd_ok, err, commit;
    logic [DATA_W-1:0]    per_rd, self_rd;

    assign slot     = paddr_i[ADDR_W-1:SLOT_BITS];
    assign ofs      = paddr_i[SLOT_BITS-1:0];
    assign locked_o = !apb_q_i[SELF_IDX] || !ahb_q_i[BRG_IDX];
    assign is_self  = (slot == SELF_SLOT);
    assign in_range = (32'(slot) < N_APB);

    always_comb begin
        slot_on = 1'b0;
        per_rd  = '0;
        for (int unsigned k = 0; k < N_APB; k++) begin
            if (32'(slot) == k) begin
                slot_on = apb_q_i[k];
                per_rd  = per_prdata_i[k*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_AHB: self_rd = DATA_W'(ahb_q_i);
            OFS_APB: self_rd = DATA_W'(apb_q_i);
            default: self_rd = '0;
        endcase
    end

    assign fwd_ok = !locked_o && !is_self && in_range && slot_on;
    assign err    = locked_o || (!is_self && !fwd_ok);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            S_IDLE:   state_d = (psel_i && !penable_i) ? S_ACCESS : S_IDLE;
            S_ACCESS: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pready_o   = 1'b0;
        pslverr_o  = 1'b0;
        prdata_o   = '0;
        commit     = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_ACCESS: begin
                pready_o  = 1'b1;
                pslverr_o = err;
                commit    = psel_i && penable_i && !err;
                if (commit && !pwrite_i) prdata_o = is_self ? self_rd : per_rd;
            end
            default: ;
        endcase
        wr_ahb_o = commit && pwrite_i && is_self && (ofs == OFS_AHB);
        wr_apb_o = commit && pwrite_i && is_self && (ofs == OFS_APB);
        for (int unsigned k = 0; k < N_APB; k++)
            per_psel_o[k] = psel_i && fwd_ok && (32'(slot) == k);
    end
endmodule

// File: rtl/periph_clk_mask.sv
`timescale 1ns/1ps
module periph_clk_mask
    import pcm_pkg::*;
#(
    parameter int unsigned      N_AHB     = 8,
    parameter int unsigned      N_APB     = 8,
    parameter logic [N_AHB-1:0] DEF_AHB   = 8'b0001_1111,
    parameter logic [N_APB-1:0] DEF_APB   = 8'b1010_0111,
    parameter int unsigned      ADDR_W    = 11,
    parameter int unsigned      SLOT_BITS = 8,
    parameter int unsigned      SELF_IDX  = 0,
    parameter int unsigned      BRG_IDX   = 0
) (
    input  logic                    pclk_i,
    input  logic                    hclk_i,
    input  logic                    rst_ni,
    input  logic                    psel_i,
    input  logic                    penable_i,
    input  logic                    pwrite_i,
    input  logic [ADDR_W-1:0]       paddr_i,
    input  logic [31:0]             pwdata_i,
    output logic [31:0]             prdata_o,
    output logic                    pready_o,
    output logic                    pslverr_o,
    output logic [N_APB-1:0]        per_psel_o,
    output logic                    per_penable_o,
    output logic                    per_pwrite_o,
    output logic [SLOT_BITS-1:0]    per_paddr_o,
    output logic [31:0]             per_pwdata_o,
    input  logic [N_APB*32-1:0]     per_prdata_i,
    output logic [N_AHB-1:0]        ahb_gclk_o,
    output logic [N_APB-1:0]        apb_gclk_o
);
    logic [N_AHB-1:0] ahb_q;
    logic [N_APB-1:0] apb_q;
    logic             wr_ahb, wr_apb, locked;

    assign per_penable_o = penable_i;
    assign per_pwrite_o  = pwrite_i;
    assign per_paddr_o   = paddr_i[SLOT_BITS-1:0];
    assign per_pwdata_o  = pwdata_i;

    pcm_mask_regs #(
        .N_AHB(N_AHB), .N_APB(N_APB), .DEF_AHB(DEF_AHB), .DEF_APB(DEF_APB)
    ) u_regs (
        .clk_i    (pclk_i),
        .rst_ni   (rst_ni),
        .wr_ahb_i (wr_ahb),
        .wr_apb_i (wr_apb),
        .ahb_wd_i (pwdata_i[N_AHB-1:0]),
        .apb_wd_i (pwdata_i[N_APB-1:0]),
        .ahb_q_o  (ahb_q),
        .apb_q_o  (apb_q)
    );

    pcm_bus_fsm #(
        .N_AHB(N_AHB), .N_APB(N_APB), .ADDR_W(ADDR_W), .SLOT_BITS(SLOT_BITS),
        .SELF_IDX(SELF_IDX), .BRG_IDX(BRG_IDX)
    ) u_fsm (
        .clk_i        (pclk_i),
        .rst_ni       (rst_ni),
        .psel_i       (psel_i),
        .penable_i    (penable_i),
        .pwrite_i     (pwrite_i),
        .paddr_i      (paddr_i),
        .ahb_q_i      (ahb_q),
        .apb_q_i      (apb_q),
        .per_prdata_i (per_prdata_i),
        .prdata_o     (prdata_o),
        .pready_o     (pready_o),
        .pslverr_o    (pslverr_o),
        .wr_ahb_o     (wr_ahb),
        .wr_apb_o     (wr_apb),
        .per_psel_o   (per_psel_o),
        .locked_o     (locked)
    );

    for (genvar g = 0; g < N_AHB; g++) begin : g_ahb_gate
        pcm_clk_gate u_gate (.clk_i(hclk_i), .en_i(ahb_q[g]), .gclk_o(ahb_gclk_o[g]));
    end

    for (genvar g = 0; g < N_APB; g++) begin : g_apb_gate
        pcm_clk_gate u_gate (.clk_i(pclk_i), .en_i(apb_q[g]), .gclk_o(apb_gclk_o[g]));
    end
endmodule

// File: rtl/pcm_mask_chk.sv
`timescale 1ns/1ps
module pcm_mask_chk #(
    parameter int unsigned N_AHB = 8,
    parameter int unsigned N_APB = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             psel_i,
    input logic             penable_i,
    input logic             pwrite_i,
    input logic             pready_i,
    input logic             pslverr_i,
    input logic [31:0]      prdata_i,
    input logic [N_APB-1:0] per_psel_i,
    input logic [N_AHB-1:0] ahb_q_i,
    input logic [N_APB-1:0] apb_q_i,
    input logic             locked_i
);
    p_onehot_fwd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(per_psel_i));

    p_fwd_only_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (per_psel_i & ~apb_q_i) == '0);

    p_err_zero_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pready_i && pslverr_i) |-> (prdata_i == 32'h0));

    p_ready_after_setup_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (psel_i && !penable_i && !pready_i) |=> pready_i);

    p_single_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pready_i |=> !pready_i);

    p_lock_no_fwd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_i |-> (per_psel_i == '0));

    p_lock_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_i && pready_i) |-> pslverr_i);

    p_lock_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_i && pready_i && pwrite_i) |=> ($stable(ahb_q_i) && $stable(apb_q_i)));

    p_lock_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_i |=> locked_i);
endmodule

bind periph_clk_mask pcm_mask_chk #(.N_AHB(N_AHB), .N_APB(N_APB)) u_chk (
    .clk_i      (pclk_i),
    .rst_ni     (rst_ni),
    .psel_i     (psel_i),
    .penable_i  (penable_i),
    .pwrite_i   (pwrite_i),
    .pready_i   (pready_o),
    .pslverr_i  (pslverr_o),
    .prdata_i   (prdata_o),
    .per_psel_i (per_psel_o),
    .ahb_q_i    (ahb_q),
    .apb_q_i    (apb_q),
    .locked_i   (locked)
);

// File: tb/periph_clk_mask_test.sv
`timescale 1ns/1ps
module periph_clk_mask_test;
    localparam int unsigned NH = 4;
    localparam int unsigned NP = 6;
    localparam logic [NH-1:0] DH = 4'b1011;
    localparam logic [NP-1:0] DP = 6'b100101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [10:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic pready, pslverr;
    logic [NP-1:0] per_psel;
    logic per_penable, per_pwrite;
    logic [7:0] per_paddr;
    logic [31:0] per_pwdata;
    logic [NP*32-1:0] stub_rd;
    logic [NH-1:0] ahb_gclk;
    logic [NP-1:0] apb_gclk;

    int checks = 0;
    int errors = 0;
    int fwd_cnt = 0;
    bit done = 0;
    logic [NH-1:0] snap_ahb;
    logic [NP-1:0] snap_apb;

    always #5 clk = ~clk;

    for (genvar g = 0; g < NP; g++) begin : g_stub
        assign stub_rd[g*32 +: 32] = 32'h5000_0000 + 32'(g);
    end

    always @(posedge clk) if (rst_n && per_penable && (per_psel != '0)) fwd_cnt++;

    periph_clk_mask #(
        .N_AHB(NH), .N_APB(NP), .DEF_AHB(DH), .DEF_APB(DP),
        .ADDR_W(11), .SLOT_BITS(8), .SELF_IDX(0), .BRG_IDX(0)
    ) uut (
        .pclk_i(clk), .hclk_i(clk), .rst_ni(rst_n),
        .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
        .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
        .pready_o(pready), .pslverr_o(pslverr),
        .per_psel_o(per_psel), .per_penable_o(per_penable),
        .per_pwrite_o(per_pwrite), .per_paddr_o(per_paddr),
        .per_pwdata_o(per_pwdata), .per_prdata_i(stub_rd),
        .ahb_gclk_o(ahb_gclk), .apb_gclk_o(apb_gclk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic [10:0] a, input logic w, input logic [31:0] wd,
                       output logic [31:0] rd, output logic er);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = wd;
        #2 chk("R9 setup ready", 32'(pready), 0);
        @(negedge clk);
        penable = 1;
        #2 chk("R9 access ready", 32'(pready), 1);
        rd = prdata; er = pslverr;
        @(posedge clk);
        #2 snap_ahb = ahb_gclk; snap_apb = apb_gclk;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic gclk_chk(input string req, input logic [NH-1:0] eh, input logic [NP-1:0] ep);
        @(posedge clk);
        #2 chk({req, " ahb high"}, 32'(ahb_gclk), 32'(eh));
        chk({req, " apb high"}, 32'(apb_gclk), 32'(ep));
        #5 chk("R3 gated low phase", {ahb_gclk, apb_gclk}, '0);
    endtask

    task automatic t_reset;
        logic [31:0] rd; logic er;
        gclk_chk("R1 default clocks", DH, DP);
        bus(11'h000, 0, 0, rd, er); chk("R1 ahb default", rd, 32'(DH)); chk("R1 ahb err", 32'(er), 0);
        bus(11'h004, 0, 0, rd, er); chk("R1 apb default", rd, 32'(DP)); chk("R4 apb err", 32'(er), 0);
    endtask

    task automatic t_forward;
        logic [31:0] rd; logic er; int c0;
        c0 = fwd_cnt;
        bus(11'h210, 0, 0, rd, er);
        chk("R6 read data slot2", rd, 32'h5000_0002); chk("R6 err", 32'(er), 0);
        chk("R6 forwarded", 32'(fwd_cnt - c0), 1);
        bus(11'h534, 1, 32'hDEAD_BEEF, rd, er);
        chk("R6 write err", 32'(er), 0); chk("R6 write forwarded", 32'(fwd_cnt - c0), 2);
    endtask

    task automatic t_blocked;
        logic [31:0] rd; logic er; int c0;
        c0 = fwd_cnt;
        bus(11'h100, 0, 0, rd, er);
        chk("R7 masked read err", 32'(er), 1); chk("R7 masked read data", rd, 0);
        bus(11'h304, 1, 32'h1234_5678, rd, er);
        chk("R7 masked write err", 32'(er), 1);
        bus(11'h600, 0, 0, rd, er);
        chk("R7 unpopulated slot err", 32'(er), 1); chk("R7 unpopulated data", rd, 0);
        chk("R7 nothing forwarded", 32'(fwd_cnt - c0), 0);
    endtask

    task automatic t_enable;
        logic [31:0] rd; logic er;
        bus(11'h004, 1, 32'h27, rd, er);
        chk("R3 no change in write high phase", 32'(snap_apb), 32'(DP));
        gclk_chk("R2 enable bit1", DH, 6'b100111);
        bus(11'h100, 0, 0, rd, er);
        chk("R8 reenabled read", rd, 32'h5000_0001); chk("R8 reenabled err", 32'(er), 0);
        bus(11'h004, 1, 32'h25, rd, er);
        gclk_chk("R2 disable bit1", DH, DP);
        bus(11'h100, 0, 0, rd, er);
        chk("R7 masked again err", 32'(er), 1);
    endtask

    task automatic t_fields;
        logic [31:0] rd; logic er;
        bus(11'h000, 1, 32'hFFFF_FFF5, rd, er);
        gclk_chk("R4 ahb write clocks", 4'b0101, DP);
        bus(11'h000, 0, 0, rd, er); chk("R4 upper bits ignored", rd, 32'h5);
        bus(11'h004, 0, 0, rd, er); chk("R4 apb independent", rd, 32'(DP));
        bus(11'h008, 1, 32'hFFFF_FFFF, rd, er); chk("R5 spare write err", 32'(er), 0);
        bus(11'h008, 0, 0, rd, er);
        chk("R5 spare offset reads 0", rd, 0); chk("R5 spare err", 32'(er), 0);
        bus(11'h000, 1, 32'hB, rd, er);
        bus(11'h000, 0, 0, rd, er); chk("R4 ahb restored", rd, 32'hB);
    endtask

    task automatic async_reset;
        @(negedge clk);
        #3 rst_n = 0;
        #11 rst_n = 1;
    endtask

    task automatic t_lock_self;
        logic [31:0] rd; logic er; int c0;
        bus(11'h004, 1, 32'h24, rd, er); chk("R10 clearing write accepted", 32'(er), 0);
        c0 = fwd_cnt;
        bus(11'h004, 1, 32'h3F, rd, er); chk("R10 locked write err", 32'(er), 1);
        gclk_chk("R10 locked write ignored", DH, 6'b100100);
        bus(11'h004, 0, 0, rd, er);
        chk("R10 locked read err", 32'(er), 1); chk("R10 locked read data", rd, 0);
        bus(11'h200, 0, 0, rd, er); chk("R10 locked periph err", 32'(er), 1);
        chk("R10 locked no forward", 32'(fwd_cnt - c0), 0);
        async_reset();
        gclk_chk("R11 defaults after reset", DH, DP);
        bus(11'h004, 0, 0, rd, er);
        chk("R11 apb after reset", rd, 32'(DP)); chk("R11 err after reset", 32'(er), 0);
    endtask

    task automatic t_lock_bridge;
        logic [31:0] rd; logic er;
        bus(11'h000, 1, 32'hA, rd, er); chk("R10 bridge clear accepted", 32'(er), 0);
        bus(11'h000, 1, 32'hF, rd, er); chk("R10 bridge locked err", 32'(er), 1);
        gclk_chk("R10 bridge lock ignored", 4'b1010, DP);
        bus(11'h500, 0, 0, rd, er); chk("R10 bridge periph err", 32'(er), 1);
        async_reset();
        gclk_chk("R11 bridge reset clocks", DH, DP);
        bus(11'h000, 0, 0, rd, er); chk("R11 ahb after reset", rd, 32'(DH));
    endtask

    initial begin
        #23 rst_n = 1;
        t_reset();
        t_forward();
        t_blocked();
        t_enable();
        t_fields();
        t_lock_self();
        t_lock_bridge();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule